// File: doc/BRIEF.md
# Edge-Order Pulse Generator

This block watches two clean, clock-synchronous inputs, A and B, and drives a pulse output. The output rises when both of two events have occurred, counting from the moment the block last became idle: A falling and B rising. The rise is timed by whichever of the two events arrives second. If both arrive in the same clock cycle, the output rises on that cycle. Each input edge is found by comparing the input with its value one clock earlier. The result is registered, so the output always moves a fixed two clock cycles after the input edge that causes the change.

A static mode input selects how the pulse ends.
- **Width-copy mode** (`fall_mode` = 0): the pulse stays high for the number of clock cycles that A was last measured high, so the output follows A's duty.
- **B-release mode** (`fall_mode` = 1): the pulse drops after B falls.

While the pulse is high, new edge orderings are not tracked. Ordering starts again only once the output is back low.

The ordering controller has four states:
- `ST_IDLE`: nothing seen yet.
- `ST_A_FIRST`: A has fallen; waiting for B to rise.
- `ST_B_FIRST`: B has risen; waiting for A to fall.
- `ST_PULSE`: the output is high.

Its transitions are:
- idle → A-first on an A fall alone.
- idle → B-first on a B rise alone.
- idle → pulse when both edges arrive together.
- A-first → pulse on a B rise.
- B-first → pulse on an A fall.
- pulse → idle when the mode's end condition is met.

Top module: `edge_order_pulse_gen`

## Requirements
- R1: The output changes exactly two clock cycles after the input edge that triggers the change: it is still at its old value one cycle after the edge and at its new value two cycles after it.
- R2: If B rises before A falls, the output rises two cycles after A's falling edge and stays low while only B has risen.
- R3: If A falls before B rises, the output stays low while waiting and rises two cycles after B's rising edge.
- R4: If A's falling edge and B's rising edge fall in the same clock cycle, the output rises two cycles after that cycle.
- R5: With `fall_mode` = 0, the output stays high for exactly as many clock cycles as A was sampled high in its most recent high phase.
- R6: With `fall_mode` = 1, the output stays high for as long as B stays high, whatever A's high time, and goes low two cycles after B falls.
- R7: Edges of A or B that arrive while the output is high do not change the pulse length. They leave no pending trigger once the output returns low.
- R8: With `fall_mode` = 0, a measured A high time of one cycle (or zero) gives an output pulse of exactly one clock cycle.
- R9: The A high-time measure saturates at 2^CNT_W−1. A longer A high phase in `fall_mode` = 0 gives a pulse of exactly 2^CNT_W−1 cycles.
- R10: An active-low asynchronous reset drives the output low at once and returns the ordering controller to idle. After release, a fresh B-then-A sequence produces a normal pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 1 | Conditioned input A, synchronous to clk |
| b_in | input | 1 | Conditioned input B, synchronous to clk |
| fall_mode | input | 1 | Static end-of-pulse select: 0 copies A's high time, 1 ends on B falling |
| pulse_out | output | 1 | Generated pulse |

## Verification
The rise rule is tried with three input orderings:
- B rising well before A falls.
- A falling several cycles before B rises.
- Both edges in one cycle.

Each of these checks the output at one and two cycles after the deciding edge. This distinguishes a correct ordering decision from one that reacts to the first edge or adds a cycle of latency.

Pulse ends are tried with several A high times (1, 3, 4, 7 and beyond saturation) to separate a copied width from an off-by-one or a stale measurement. B-release mode holds B high long past A's width to show that the width copy is not used there. Extra edges during a pulse, and a reset in mid-pulse, show that re-arming waits for the output to fall.

// File: rtl/edge_pulse_pkg.sv
package edge_pulse_pkg;

    // Ordering controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_A_FIRST = 2'd1,
        ST_B_FIRST = 2'd2,
        ST_PULSE   = 2'd3
    } ord_state_e;

    // Index of each input in the edge detector array
    localparam int SIG_A = 0;
    localparam int SIG_B = 1;
    localparam int NUM_SIGS = 2;

endpackage

// File: rtl/ep_edge_det.sv
// Registered rise/fall detector: pulses one cycle after the sampled change.
module ep_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);

    logic dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q  <= 1'b0;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            dly_q  <= sig_i;
            rise_o <= sig_i & ~dly_q;
            fall_o <= dly_q & ~sig_i;
        end
    end

endmodule

// File: rtl/ep_width_meter.sv
// Counts the cycles between the registered rise and fall pulses of A.
// The width output bypasses the fall cycle so the fresh value is usable at once.
module ep_width_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic [CNT_W-1:0] width_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             active_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] meas_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            run_q    <= '0;
            meas_q   <= '0;
        end else begin
            if (rise_i) begin
                active_q <= 1'b1;
                run_q    <= CNT_ONE;
            end else if (fall_i) begin
                active_q <= 1'b0;
                meas_q   <= run_q;
            end else if (active_q && (run_q != CNT_MAX)) begin
                run_q <= run_q + CNT_ONE;
            end
        end
    end

    assign width_o = fall_i ? run_q : meas_q;

endmodule

// File: rtl/ep_order_fsm.sv
// Tracks which of A-fall / B-rise came first, then times the output pulse.
module ep_order_fsm
    import edge_pulse_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_fall_i,
    input  logic             b_rise_i,
    input  logic             b_fall_i,
    input  logic             fall_mode_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pulse_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ord_state_e       state_q, state_d;
    logic [CNT_W-1:0] rem_q;
    logic             pulse_done;
    logic             entering;

    assign pulse_done = fall_mode_i ? b_fall_i : (rem_q <= CNT_ONE);
    assign entering   = (state_q != ST_PULSE) && (state_d == ST_PULSE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (a_fall_i && b_rise_i) state_d = ST_PULSE;
                else if (a_fall_i)        state_d = ST_A_FIRST;
                else if (b_rise_i)        state_d = ST_B_FIRST;
            end
            ST_A_FIRST: if (b_rise_i)   state_d = ST_PULSE;
            ST_B_FIRST: if (a_fall_i)   state_d = ST_PULSE;
            ST_PULSE:   if (pulse_done) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs: pulse level and remaining-width down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
            rem_q   <= '0;
        end else begin
            pulse_o <= (state_d == ST_PULSE);
            if (entering)
                rem_q <= width_i;
            else if ((state_q == ST_PULSE) && (rem_q > CNT_ONE))
                rem_q <= rem_q - CNT_ONE;
        end
    end

endmodule

// File: rtl/edge_order_pulse_gen.sv
module edge_order_pulse_gen
    import edge_pulse_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_in,
    input  logic b_in,
    input  logic fall_mode,
    output logic pulse_out
);

    logic [NUM_SIGS-1:0] sig_vec;
    logic [NUM_SIGS-1:0] rise_p;
    logic [NUM_SIGS-1:0] fall_p;
    logic [CNT_W-1:0]    a_width;

    assign sig_vec[SIG_A] = a_in;
    assign sig_vec[SIG_B] = b_in;

    for (genvar g = 0; g < NUM_SIGS; g++) begin : g_edge
        ep_edge_det u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (sig_vec[g]),
            .rise_o (rise_p[g]),
            .fall_o (fall_p[g])
        );
    end

    ep_width_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_p[SIG_A]),
        .fall_i  (fall_p[SIG_A]),
        .width_o (a_width)
    );

    ep_order_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .a_fall_i    (fall_p[SIG_A]),
        .b_rise_i    (rise_p[SIG_B]),
        .b_fall_i    (fall_p[SIG_B]),
        .fall_mode_i (fall_mode),
        .width_i     (a_width),
        .pulse_o     (pulse_out)
    );

endmodule

// File: rtl/edge_order_pulse_chk.sv
module edge_order_pulse_chk #(
    parameter int CNT_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic a_in,
    input logic b_in,
    input logic fall_mode,
    input logic pulse_out
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           hi_q <= '0;
        else if (!pulse_out)                  hi_q <= '0;
        else if (hi_q != CNT_MAX)             hi_q <= hi_q + CNT_W'(1);
    end

    // R2
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |->
            (($past(a_in, 3) && !$past(a_in, 2)) || (!$past(b_in, 3) && $past(b_in, 2))));

    // R6
    b_release_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_mode && $fell(pulse_out)) |-> ($past(b_in, 3) && !$past(b_in, 2)));

    // R9
    width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && !fall_mode) |-> (hi_q != CNT_MAX));

    // R10
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_low_chk: assert (!pulse_out);
        end
    end

endmodule

bind edge_order_pulse_gen edge_order_pulse_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .b_in      (b_in),
    .fall_mode (fall_mode),
    .pulse_out (pulse_out)
);

// File: tb/edge_order_pulse_gen_tb_top.sv
module edge_order_pulse_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TB_CNT_W   = 6;
    localparam int SAT_WIDTH  = (1 << TB_CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_in = 1'b0;
    logic b_in = 1'b0;
    logic fall_mode = 1'b0;
    logic pulse_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    edge_order_pulse_gen #(.CNT_W(TB_CNT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_in      (a_in),
        .b_in      (b_in),
        .fall_mode (fall_mode),
        .pulse_out (pulse_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pulse_out actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: pulse width actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at the first negedge where the pulse is seen high.
    task automatic count_high(output int w);
        w = 0;
        while (pulse_out === 1'b1 && w < 300) begin
            w++;
            step(1);
        end
    endtask

    task automatic t_reset_state();
        step(1);
        chk_bit("R10 in reset", pulse_out, 1'b0);
        step(2);
        rst_n = 1'b1;
        step(4);
        chk_bit("R10 after release", pulse_out, 1'b0);
    endtask

    task automatic t_b_first();
        int w;
        fall_mode = 1'b0;
        a_in = 1'b1;
        step(3);
        b_in = 1'b1;
        step(3);
        chk_bit("R2 wait for A fall", pulse_out, 1'b0);
        step(1);
        a_in = 1'b0;                    // A high for 7 sampled cycles
        step(1);
        chk_bit("R1 one cycle after A fall", pulse_out, 1'b0);
        step(1);
        chk_bit("R2 rise two cycles after A fall", pulse_out, 1'b1);
        count_high(w);
        chk_int("R5 width 7", w, 7);
        b_in = 1'b0;
        step(3);
    endtask

    task automatic t_a_first();
        int w;
        a_in = 1'b1;
        step(4);
        a_in = 1'b0;
        step(5);
        chk_bit("R3 wait for B rise", pulse_out, 1'b0);
        b_in = 1'b1;
        step(1);
        chk_bit("R1 one cycle after B rise", pulse_out, 1'b0);
        step(1);
        chk_bit("R3 rise two cycles after B rise", pulse_out, 1'b1);
        count_high(w);
        chk_int("R5 most recent width 4", w, 4);
        b_in = 1'b0;
        step(3);
    endtask

    task automatic t_same_cycle();
        int w;
        a_in = 1'b1;
        step(3);
        a_in = 1'b0;
        b_in = 1'b1;
        step(1);
        chk_bit("R4 one cycle after joint edges", pulse_out, 1'b0);
        step(1);
        chk_bit("R4 rise on joint edges", pulse_out, 1'b1);
        count_high(w);
        chk_int("R5 width 3", w, 3);
        b_in = 1'b0;
        step(3);
    endtask

    task automatic t_b_release_mode();
        fall_mode = 1'b1;
        step(1);
        a_in = 1'b1;
        step(2);
        a_in = 1'b0;
        b_in = 1'b1;
        step(2);
        chk_bit("R6 rise in B-release mode", pulse_out, 1'b1);
        for (int i = 0; i < 12; i++) begin
            step(1);
            chk_bit("R6 held while B high", pulse_out, 1'b1);
        end
        b_in = 1'b0;
        step(1);
        chk_bit("R6 one cycle after B fall", pulse_out, 1'b1);
        step(1);
        chk_bit("R6 low two cycles after B fall", pulse_out, 1'b0);
        fall_mode = 1'b0;
        step(3);
    endtask

    task automatic t_retrigger_ignored();
        a_in = 1'b1;
        step(10);
        a_in = 1'b0;
        b_in = 1'b1;
        for (int i = 1; i <= 22; i++) begin
            step(1);
            chk_bit("R7 pulse unaffected by extra edges", pulse_out, (i >= 2 && i <= 11));
            if (i == 3) b_in = 1'b0;
            if (i == 4) begin
                b_in = 1'b1;
                a_in = 1'b1;
            end
            if (i == 5) a_in = 1'b0;
        end
        b_in = 1'b0;
        step(3);
        chk_bit("R7 no pending trigger", pulse_out, 1'b0);
    endtask

    task automatic t_single_cycle();
        a_in = 1'b1;
        step(1);
        a_in = 1'b0;
        b_in = 1'b1;
        step(2);
        chk_bit("R8 one-cycle pulse high", pulse_out, 1'b1);
        step(1);
        chk_bit("R8 one-cycle pulse ends", pulse_out, 1'b0);
        b_in = 1'b0;
        step(3);
    endtask

    task automatic t_saturate();
        int w;
        a_in = 1'b1;
        step(100);
        a_in = 1'b0;
        b_in = 1'b1;
        step(2);
        chk_bit("R9 rise after long A", pulse_out, 1'b1);
        count_high(w);
        chk_int("R9 saturated width", w, SAT_WIDTH);
        b_in = 1'b0;
        step(3);
    endtask

    task automatic t_async_reset();
        int w;
        fall_mode = 1'b1;
        a_in = 1'b1;
        step(2);
        a_in = 1'b0;
        b_in = 1'b1;
        step(2);
        chk_bit("R10 pulse before reset", pulse_out, 1'b1);
        #2 rst_n = 1'b0;
        #1 chk_bit("R10 async clear", pulse_out, 1'b0);
        a_in = 1'b0;
        b_in = 1'b0;
        fall_mode = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(4);
        chk_bit("R10 idle after reset", pulse_out, 1'b0);
        b_in = 1'b1;
        step(3);
        chk_bit("R10 B-first waits", pulse_out, 1'b0);
        a_in = 1'b1;
        step(2);
        a_in = 1'b0;
        step(2);
        chk_bit("R10 normal pulse after reset", pulse_out, 1'b1);
        count_high(w);
        chk_int("R10 width after reset", w, 2);
        b_in = 1'b0;
        step(3);
    endtask

    initial begin
        t_reset_state();
        t_b_first();
        t_a_first();
        t_same_cycle();
        t_b_release_mode();
        t_retrigger_ignored();
        t_single_cycle();
        t_saturate();
        t_async_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run incomplete, actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule